// File: doc/BRIEF.md
# Processor Status Flag Register with ALU

This block keeps the 8-bit status word of a small accumulator-style processor and contains the 8-bit ALU that drives its arithmetic flags. On any cycle, the ALU combines a working value `w_val` with a register operand `f_val`. The supported operations are add, subtract, three bitwise logic operations, clear, and rotate through carry. The result appears at once on `result`. At the next rising clock edge, the zero, digit-carry and carry flags are updated, but only those flags the chosen operation affects.

The status word has three further groups of bits:
- two bank-select bits (bits 6:5);
- a reserved indirect bank bit (bit 7);
- two reset-cause flags (bits 4:3), which only event strobes can change.

The surrounding core can make the status word the destination of an ALU operation with `dest_sel`. In that case the upper three bits take the result, but the result never reaches the three flag bits: they follow the ALU flags instead. Bit-set, bit-clear, nibble-swap and move operations change no flags. The core performs them through the plain write port `wr_en`/`wr_data`, which writes every writable bit.

Top module: `status_flag_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the status word becomes 8'h18: bits 7:5 are 0, bit 4 (timeout flag) and bit 3 (power-down flag) are 1, and bits 2:0 are 0.
- R2: `op_code` 0 adds (`f_val + w_val`). Bit 0 (carry) is set by a carry out of bit 7. Bit 1 (digit carry) is set by a carry out of bit 3. Bit 2 (zero) is set when the 8-bit result is 0.
- R3: `op_code` 1 subtracts (`f_val - w_val`) by adding the two's complement of `w_val`. Carry reads 1 when `f_val >= w_val`. Digit carry reads 1 when the low nibble of `f_val` is greater than or equal to the low nibble of `w_val`. Zero is set when the result is 0.
- R4: `op_code` 2, 3 and 4 give AND, inclusive OR and exclusive OR. They update zero only and leave carry and digit carry unchanged.
- R5: `op_code` 5 (clear) gives result 0, sets zero, and leaves carry and digit carry unchanged. With `dest_sel` set, the status word becomes {3'b000, timeout, power-down, 1, digit carry, carry}.
- R6: `op_code` 6 rotates right: result = {carry, f_val[7:1]} and the new carry = f_val[0]. `op_code` 7 rotates left: result = {f_val[6:0], carry} and the new carry = f_val[7]. Zero and digit carry are unchanged.
- R7: On an ALU operation with `dest_sel` high, bits 7:5 take `result[7:5]`. Bits 2:0 take only the ALU flags, or keep their value for flags the operation does not affect. Bits 4:3 are not touched by the data.
- R8: A plain write (`wr_en` high, `op_valid` low) loads bits 7:5 and 2:0 from `wr_data` and leaves bits 4:3 unchanged.
- R9: When `op_valid` and `wr_en` are high in the same cycle, the ALU operation is applied and the plain write is dropped.
- R10: Event strobes set the timeout and power-down flags:
  - `ev_wdt_clr` sets both to 1;
  - otherwise `ev_sleep` sets timeout to 1 and power-down to 0;
  - otherwise `ev_wdt_to` clears timeout.

  With no event, both flags hold.
- R11: An event and a data update in the same cycle both take effect. The event owns bits 4:3 and the data update owns the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| op_valid | input | 1 | Execute the ALU operation this cycle |
| op_code | input | 3 | ALU operation select (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 clear, 6 rotate right, 7 rotate left) |
| w_val | input | 8 | Working operand |
| f_val | input | 8 | Register operand |
| dest_sel | input | 1 | The ALU result is written to the status word |
| wr_en | input | 1 | Plain write of the status word (no flag override) |
| wr_data | input | 8 | Data for the plain write |
| ev_wdt_clr | input | 1 | Watchdog-clear event strobe |
| ev_sleep | input | 1 | Sleep event strobe |
| ev_wdt_to | input | 1 | Watchdog-timeout event strobe |
| result | output | 8 | ALU result (combinational) |
| status | output | 8 | Status word |

## Verification
The functions that meet in one cycle are of two kinds:
- an ALU operation aimed at the status word, which competes with the data path for the flag bits;
- an event strobe arriving together with a data update, which shares the register with it.

The bench drives each collision on purpose: a clear into the status word after the flags were all set, an operation and a plain write together, and a sleep strobe alongside a write of 8'hFF. A long stretch of random stimulus then lets all of these overlap freely. A behavioural model judges every cycle: it computes flags from integer arithmetic and applies the priorities stated in the requirements, then the bench compares both `result` and `status` with it.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned BIT_C  = 0;
    localparam int unsigned BIT_DC = 1;
    localparam int unsigned BIT_Z  = 2;
    localparam int unsigned BIT_PD = 3;
    localparam int unsigned BIT_TO = 4;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h18;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_IOR = 3'd3,
        OP_XOR = 3'd4,
        OP_CLR = 3'd5,
        OP_RRC = 3'd6,
        OP_RLC = 3'd7
    } alu_op_e;

    // packed order matches status bits 2:0
    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        logic to;
        logic pd;
    } cause_t;

    function automatic flags_t touched_by(alu_op_e op);
        flags_t m;
        case (op)
            OP_ADD, OP_SUB: m = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            OP_RRC, OP_RLC: m = '{z: 1'b0, dc: 1'b0, c: 1'b1};
            default:        m = '{z: 1'b1, dc: 1'b0, c: 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/status_alu.sv
module status_alu
    import status_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   value,
    output flags_t         flg,
    output flags_t         touch
);
    localparam int unsigned H = W / 2;

    logic           is_sub;
    logic [W-1:0]   addend;
    logic [W:0]     sum;
    logic [H:0]     hsum;

    assign is_sub = (op == OP_SUB);
    assign addend = is_sub ? ~a : a;
    assign sum    = {1'b0, b} + {1'b0, addend} + {{W{1'b0}}, is_sub};
    assign hsum   = {1'b0, b[H-1:0]} + {1'b0, addend[H-1:0]} + {{H{1'b0}}, is_sub};

    always_comb begin
        value  = '0;
        flg.c  = 1'b0;
        flg.dc = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                value  = sum[W-1:0];
                flg.c  = sum[W];
                flg.dc = hsum[H];
            end
            OP_AND: value = a & b;
            OP_IOR: value = a | b;
            OP_XOR: value = a ^ b;
            OP_CLR: value = '0;
            OP_RRC: begin
                value = {cin, b[W-1:1]};
                flg.c = b[0];
            end
            OP_RLC: begin
                value = {b[W-2:0], cin};
                flg.c = b[W-1];
            end
            default: value = '0;
        endcase
        flg.z = (value == '0);
    end

    assign touch = touched_by(op);

endmodule

// File: rtl/status_evt.sv
module status_evt
    import status_pkg::*;
(
    input  cause_t cur,
    input  logic   wdt_clr,
    input  logic   sleep_req,
    input  logic   wdt_tmo,
    output cause_t nxt
);
    always_comb begin
        nxt = cur;
        if (wdt_clr) begin
            nxt.to = 1'b1;
            nxt.pd = 1'b1;
        end else if (sleep_req) begin
            nxt.to = 1'b1;
            nxt.pd = 1'b0;
        end else if (wdt_tmo) begin
            nxt.to = 1'b0;
        end
    end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_pkg::*;
#(
    parameter int unsigned DW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] w_val,
    input  logic [DW-1:0] f_val,
    input  logic          dest_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ev_wdt_clr,
    input  logic          ev_sleep,
    input  logic          ev_wdt_to,
    output logic [DW-1:0] result,
    output logic [DW-1:0] status
);
    localparam int unsigned NFLG = 3;
    localparam int unsigned UP_LO = BIT_TO + 1;

    logic [DW-1:0]   st_q;
    logic [DW-1:0]   st_d;
    flags_t          alu_flg;
    flags_t          alu_touch;
    logic [NFLG-1:0] flag_mix;
    cause_t          cause_d;

    status_alu #(.W(DW)) u_alu (
        .op    (alu_op_e'(op_code)),
        .a     (w_val),
        .b     (f_val),
        .cin   (st_q[BIT_C]),
        .value (result),
        .flg   (alu_flg),
        .touch (alu_touch)
    );

    status_evt u_evt (
        .cur       ('{to: st_q[BIT_TO], pd: st_q[BIT_PD]}),
        .wdt_clr   (ev_wdt_clr),
        .sleep_req (ev_sleep),
        .wdt_tmo   (ev_wdt_to),
        .nxt       (cause_d)
    );

    // per flag: ALU value if the operation affects it, else hold
    for (genvar i = 0; i < NFLG; i++) begin : g_flag
        assign flag_mix[i] = alu_touch[i] ? alu_flg[i] : st_q[i];
    end

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (dest_sel) begin
                st_d[DW-1:UP_LO] = result[DW-1:UP_LO];
            end
            st_d[NFLG-1:0] = flag_mix;
        end else if (wr_en) begin
            st_d[DW-1:UP_LO] = wr_data[DW-1:UP_LO];
            st_d[NFLG-1:0]   = wr_data[NFLG-1:0];
        end
        st_d[BIT_TO] = cause_d.to;
        st_d[BIT_PD] = cause_d.pd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= DW'(STAT_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;

endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [7:0] w_val,
    input logic [7:0] f_val,
    input logic       dest_sel,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ev_wdt_clr,
    input logic       ev_sleep,
    input logic       ev_wdt_to,
    input logic [7:0] result,
    input logic [7:0] status
);
    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> status == 8'h18);

    assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0) |=>
            status[0] == (({1'b0, $past(f_val)} + {1'b0, $past(w_val)}) > 9'd255));

    assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1) |=> status[0] == ($past(f_val) >= $past(w_val)));

    assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4)) |=>
            $stable(status[1:0]));

    assert_clear_sets_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5) |=> (status[2] && $stable(status[1:0])));

    assert_rrc_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd6) |=> status[0] == $past(f_val[0]));

    assert_dest_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dest_sel) |=> status[7:5] == $past(result[7:5]));

    assert_plain_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && wr_en) |=>
            {status[7:5], status[2:0]} == {$past(wr_data[7:5]), $past(wr_data[2:0])});

    assert_wdt_clr_R10: assert property (@(posedge clk) disable iff (rst)
        ev_wdt_clr |=> status[4:3] == 2'b11);

    assert_cause_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!ev_wdt_clr && !ev_sleep && !ev_wdt_to) |=> $stable(status[4:3]));

    assert_sleep_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_sleep && !ev_wdt_clr) |=> status[4:3] == 2'b10);

endmodule

bind status_flag_reg status_flag_reg_chk u_chk (.*);

// File: tb/status_flag_reg_bench.sv
`timescale 1ns/1ps
module status_flag_reg_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid, dest_sel, wr_en;
    logic [2:0] op_code;
    logic [7:0] w_val, f_val, wr_data;
    logic       ev_wdt_clr, ev_sleep, ev_wdt_to;
    logic [7:0] result, status;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    logic [7:0] m;

    always #2.5 clk = ~clk;

    status_flag_reg u_status_flag_reg (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .w_val(w_val), .f_val(f_val), .dest_sel(dest_sel), .wr_en(wr_en),
        .wr_data(wr_data), .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep),
        .ev_wdt_to(ev_wdt_to), .result(result), .status(status)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; op_code = 0; w_val = 0; f_val = 0; dest_sel = 0;
        wr_en = 0; wr_data = 0; ev_wdt_clr = 0; ev_sleep = 0; ev_wdt_to = 0;
    endtask

    // called at a falling edge; applies one cycle of stimulus and checks it
    task automatic step(string tag, bit ov, int oc, int w, int f, bit ds,
                        bit we, int wd, bit ec, bit es, bit et);
        int r, c, dc, z, aff;
        logic [7:0] nx;
        logic [7:0] wdv;
        op_valid = ov; op_code = oc[2:0]; w_val = w[7:0]; f_val = f[7:0];
        dest_sel = ds; wr_en = we; wr_data = wd[7:0];
        ev_wdt_clr = ec; ev_sleep = es; ev_wdt_to = et;
        #1;
        c = 0; dc = 0; aff = 4;
        case (oc)
            0: begin r = (f + w) % 256; c = (f + w) > 255 ? 1 : 0;
                     dc = ((f % 16) + (w % 16)) > 15 ? 1 : 0; aff = 7; end
            1: begin r = (f - w + 256) % 256; c = f >= w ? 1 : 0;
                     dc = (f % 16) >= (w % 16) ? 1 : 0; aff = 7; end
            2: r = f & w;
            3: r = f | w;
            4: r = f ^ w;
            5: r = 0;
            6: begin r = int'(m[0]) * 128 + f / 2; c = f % 2; aff = 1; end
            default: begin r = (f * 2) % 256 + int'(m[0]); c = f / 128; aff = 1; end
        endcase
        z = (r == 0) ? 1 : 0;
        if (ov) chk(tag, "result", int'(result), r);
        nx = m;
        if (ov) begin
            if (ds) nx[7:5] = r[7:5];
            if (aff >= 4) nx[2] = z[0];
            if (aff == 7) nx[1] = dc[0];
            if (aff % 2 == 1) nx[0] = c[0];
        end else if (we) begin
            wdv = wd[7:0];
            nx[7:5] = wdv[7:5];
            nx[2:0] = wdv[2:0];
        end
        if (ec) nx[4:3] = 2'b11;
        else if (es) nx[4:3] = 2'b10;
        else if (et) nx[4] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m = nx;
        idle();
        chk(tag, "status", int'(status), int'(m));
    endtask

    initial begin
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        m = 8'h18;
        chk("R1", "status", int'(status), 8'h18);

        // R2 add
        step("R2", 1, 0, 8'h01, 8'h0F, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 8'h01, 8'hFF, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 8'h20, 8'h10, 0, 0, 0, 0, 0, 0);
        chk("R2", "flags after 10+20", int'(status[2:0]), 3'b000);
        // R3 subtract
        step("R3", 1, 1, 8'h03, 8'h05, 0, 0, 0, 0, 0, 0);
        chk("R3", "no-borrow flags", int'(status[2:0]), 3'b011);
        step("R3", 1, 1, 8'h05, 8'h03, 0, 0, 0, 0, 0, 0);
        chk("R3", "borrow flags", int'(status[2:0]), 3'b000);
        step("R3", 1, 1, 8'h01, 8'h10, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 1, 8'h42, 8'h42, 0, 0, 0, 0, 0, 0);
        chk("R3", "equal flags", int'(status[2:0]), 3'b111);
        // R4 logic keeps C/DC
        step("R4", 1, 2, 8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 3, 8'hA0, 8'h05, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 4, 8'h5A, 8'h5A, 0, 0, 0, 0, 0, 0);
        // R8 plain write, R5 clear into status
        step("R8", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
        chk("R8", "write FF keeps TO/PD", int'(status), 8'hFF);
        step("R5", 1, 5, 8'h33, 8'h77, 1, 0, 0, 0, 0, 0);
        chk("R5", "clear into status", int'(status), 8'h1F);
        // R6 rotates
        step("R6", 1, 6, 0, 8'h81, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 7, 0, 8'h40, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 7, 0, 8'h80, 0, 0, 0, 0, 0, 0);
        // R7 ALU into status: data cannot reach flags
        step("R7", 1, 3, 8'hE0, 8'h07, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 8'h60, 8'h40, 1, 0, 0, 0, 0, 0);
        // R9 op beats plain write
        step("R9", 1, 2, 8'h00, 8'hFF, 0, 1, 8'hE7, 0, 0, 0);
        // R10 events and priority
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R10", "timeout clears TO", int'(status[4:3]), 2'b01);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R10", "sleep", int'(status[4:3]), 2'b10);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
        chk("R10", "clear wins", int'(status[4:3]), 2'b11);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R11 event with data update
        step("R11", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 1, 0);
        chk("R11", "sleep with write FF", int'(status), 8'hF7);
        step("R11", 1, 5, 0, 0, 1, 0, 0, 0, 0, 1);
        chk("R11", "timeout with clear", int'(status), 8'h07);
        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            step("R11", 1'($urandom % 2), int'($urandom % 8), int'($urandom % 256),
                 int'($urandom % 256), 1'($urandom % 2), 1'($urandom % 2),
                 int'($urandom % 256), ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 6) == 0);
        end
        rst = 1;
        @(negedge clk);
        rst = 0;
        m = 8'h18;
        chk("R1", "status after second reset", int'(status), 8'h18);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule